// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a root-port configuration request source and the register fabric. Each request carries a bus number, a combined device/function byte and a 12-bit register offset. One cycle after it is accepted, the block reports whether the access goes to the local register region or to the remote configuration window. It also reports the address to use and, for remote accesses, a setup word together with a one-cycle strobe that loads that word into an internal setup register.

Three access kinds exist. Bus 0 is the root port's own register space and is reached directly. Bus 1 is the virtual secondary bus, so it is reached through the remote window with a Type 0 setup word. Every bus above 1 is reached through the same window with the Type 1 flag set in the setup word. Software can read the setup register back through a small read port.

Top module: `cfgr_top`

## Requirements
- R1: After reset, `rsp_valid` and `setup_wr` are low, and a read of the setup register returns 0.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and is low otherwise.
- R3: A request to bus 0 gives `rsp_remote`=0, `rsp_kind`=0, `rsp_addr` = CFG_BASE + offset, and no `setup_wr` pulse.
- R4: For any bus other than 0, `setup_word` holds the bus in bits 23:16, the device (devfn bits 7:3) in bits 12:8 and the function (devfn bits 2:0) in bits 2:0, and all other bits except bit 24 are 0.
- R5: For a bus of 2 or more, `setup_word` bit 24 is 1 and `rsp_kind`=2 (remote Type 1).
- R6: For bus 1, `setup_word` bit 24 is 0 and `rsp_kind`=1 (remote Type 0).
- R7: A remote request gives `rsp_remote`=1 and `rsp_addr` = CFG_BASE + 0x1000 + offset.
- R8: `setup_wr` is a single-cycle pulse, high only together with `rsp_valid` for a remote request.
- R9: A read with `sw_rd_en` high and `sw_rd_addr`=0x008 returns the setup register on `sw_rd_data` in the following cycle. A read of any other address returns 0.
- R10: A read of address 0x008 sampled in the same cycle that `setup_wr` is high returns the word being loaded, not the previous one.
- R11: A bus-0 request leaves the setup register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Device in bits 7:3, function in bits 2:0 |
| req_offset | input | OFS_W (12) | Register offset within the function |
| sw_rd_en | input | 1 | Software read strobe |
| sw_rd_addr | input | APP_AW (12) | Software read byte address |
| rsp_valid | output | 1 | Routing result present |
| rsp_remote | output | 1 | 1 = remote window, 0 = local region |
| rsp_kind | output | 2 | 0 local, 1 remote Type 0, 2 remote Type 1 |
| rsp_addr | output | ADDR_W (32) | Region base plus offset |
| setup_word | output | 32 | Setup word for the remote path |
| setup_wr | output | 1 | One-cycle load strobe for the setup register |
| sw_rd_data | output | 32 | Read data, one cycle after the read |

## Verification
The two functions that can fall in the same cycle are the loading of the setup register by `setup_wr` and a software readback of that register. The bench provokes this by issuing a remote request and raising a read of address 0x008 in the very cycle when the strobe is high. The returned data must equal the new word and not the older contents. A later read must return the same word. A bus-0 request between two reads shows that the register is not disturbed.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

    typedef enum logic [1:0] {
        KIND_LOCAL  = 2'd0,
        KIND_RMT_T0 = 2'd1,
        KIND_RMT_T1 = 2'd2
    } cfg_kind_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
    } cfg_target_t;

    function automatic cfg_target_t split_target(input logic [7:0] bus,
                                                 input logic [7:0] devfn);
        cfg_target_t t;
        t.bus = bus;
        t.dev = devfn[7:3];
        t.fn  = devfn[2:0];
        return t;
    endfunction

    function automatic cfg_kind_e classify(input logic [7:0] bus);
        if (bus == 8'd0)
            return KIND_LOCAL;
        else if (bus == 8'd1)
            return KIND_RMT_T0;
        else
            return KIND_RMT_T1;
    endfunction

    function automatic logic [31:0] build_setup(input cfg_target_t t,
                                                input logic type1);
        logic [31:0] w;
        w        = '0;
        w[24]    = type1;
        w[23:16] = t.bus;
        w[12:8]  = t.dev;
        w[2:0]   = t.fn;
        return w;
    endfunction

endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
    import cfgr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          OFS_W      = 12,
    parameter logic [31:0] CFG_BASE   = 32'h4000_0000,
    parameter logic [31:0] REMOTE_OFS = 32'h0000_1000
) (
    input  logic [7:0]        bus,
    input  logic [7:0]        devfn,
    input  logic [OFS_W-1:0]  offset,
    output cfg_kind_e         kind,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       word
);
    localparam logic [ADDR_W-1:0] LOCAL_BASE  = ADDR_W'(CFG_BASE);
    localparam logic [ADDR_W-1:0] REMOTE_BASE = ADDR_W'(CFG_BASE + REMOTE_OFS);

    cfg_target_t tgt;

    always_comb begin
        tgt  = split_target(bus, devfn);
        kind = classify(bus);
        word = build_setup(tgt, kind == KIND_RMT_T1);
        if (kind == KIND_LOCAL)
            addr = LOCAL_BASE + ADDR_W'(offset);
        else
            addr = REMOTE_BASE + ADDR_W'(offset);
    end
endmodule

// File: rtl/cfgr_issue.sv
module cfgr_issue
    import cfgr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  cfg_kind_e         in_kind,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_word,
    output logic              out_valid,
    output cfg_kind_e         out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [31:0]       out_word,
    output logic              out_load
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_load  <= 1'b0;
            out_kind  <= KIND_LOCAL;
            out_addr  <= '0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            out_load  <= in_valid && (in_kind != KIND_LOCAL);
            if (in_valid) begin
                out_kind <= in_kind;
                out_addr <= in_addr;
                out_word <= (in_kind == KIND_LOCAL) ? 32'd0 : in_word;
            end
        end
    end
endmodule

// File: rtl/cfgr_setup_reg.sv
module cfgr_setup_reg #(
    parameter int          APP_AW    = 12,
    parameter logic [11:0] SETUP_OFS = 12'h008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [31:0]       load_word,
    input  logic              rd_en,
    input  logic [APP_AW-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam logic [APP_AW-1:0] HIT_ADDR = APP_AW'(SETUP_OFS);

    logic [31:0] held;
    logic [31:0] view;

    // Forward the word being loaded so a coincident read sees it.
    assign view = load ? load_word : held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held    <= '0;
            rd_data <= '0;
        end else begin
            if (load)
                held <= load_word;
            if (rd_en)
                rd_data <= (rd_addr == HIT_ADDR) ? view : 32'd0;
        end
    end
endmodule

// File: rtl/cfgr_top.sv
module cfgr_top
    import cfgr_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          OFS_W      = 12,
    parameter int          APP_AW     = 12,
    parameter logic [31:0] CFG_BASE   = 32'h4000_0000,
    parameter logic [31:0] REMOTE_OFS = 32'h0000_1000,
    parameter logic [11:0] SETUP_OFS  = 12'h008
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_bus,
    input  logic [7:0]        req_devfn,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              sw_rd_en,
    input  logic [APP_AW-1:0] sw_rd_addr,
    output logic              rsp_valid,
    output logic              rsp_remote,
    output logic [1:0]        rsp_kind,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [31:0]       setup_word,
    output logic              setup_wr,
    output logic [31:0]       sw_rd_data
);
    cfg_kind_e         dec_kind;
    logic [ADDR_W-1:0] dec_addr;
    logic [31:0]       dec_word;
    cfg_kind_e         iss_kind;

    cfgr_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W),
        .CFG_BASE(CFG_BASE), .REMOTE_OFS(REMOTE_OFS)
    ) u_dec (
        .bus(req_bus), .devfn(req_devfn), .offset(req_offset),
        .kind(dec_kind), .addr(dec_addr), .word(dec_word)
    );

    cfgr_issue #(.ADDR_W(ADDR_W)) u_iss (
        .clk(clk), .rst(rst),
        .in_valid(req_valid), .in_kind(dec_kind),
        .in_addr(dec_addr), .in_word(dec_word),
        .out_valid(rsp_valid), .out_kind(iss_kind),
        .out_addr(rsp_addr), .out_word(setup_word),
        .out_load(setup_wr)
    );

    cfgr_setup_reg #(.APP_AW(APP_AW), .SETUP_OFS(SETUP_OFS)) u_sreg (
        .clk(clk), .rst(rst),
        .load(setup_wr), .load_word(setup_word),
        .rd_en(sw_rd_en), .rd_addr(sw_rd_addr),
        .rd_data(sw_rd_data)
    );

    assign rsp_kind   = iss_kind;
    assign rsp_remote = (iss_kind != KIND_LOCAL);
endmodule

// File: rtl/cfgr_checker.sv
module cfgr_checker #(
    parameter int          APP_AW    = 12,
    parameter logic [11:0] SETUP_OFS = 12'h008
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [7:0]        req_bus,
    input logic              sw_rd_en,
    input logic [APP_AW-1:0] sw_rd_addr,
    input logic              rsp_valid,
    input logic              rsp_remote,
    input logic [1:0]        rsp_kind,
    input logic [31:0]       setup_word,
    input logic              setup_wr,
    input logic [31:0]       sw_rd_data
);
    a_r2_follows_req: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    a_r3_local_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus == 8'd0) |=> (!setup_wr && !rsp_remote));
    a_r5_type1_flag: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus > 8'd1) |=> (setup_word[24] && rsp_kind == 2'd2));
    a_r6_bus1_type0: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_bus == 8'd1) |=> (!setup_word[24] && rsp_kind == 2'd1));
    a_r8_strobe_remote: assert property (@(posedge clk) disable iff (rst)
        setup_wr |-> (rsp_valid && rsp_remote));
    a_r10_forward: assert property (@(posedge clk) disable iff (rst)
        (setup_wr && sw_rd_en && sw_rd_addr == APP_AW'(SETUP_OFS))
        |=> sw_rd_data == $past(setup_word));
endmodule

bind cfgr_top cfgr_checker #(.APP_AW(APP_AW), .SETUP_OFS(SETUP_OFS)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
    .sw_rd_en(sw_rd_en), .sw_rd_addr(sw_rd_addr),
    .rsp_valid(rsp_valid), .rsp_remote(rsp_remote), .rsp_kind(rsp_kind),
    .setup_word(setup_word), .setup_wr(setup_wr), .sw_rd_data(sw_rd_data)
);

// File: tb/sim_cfgr_top.sv
`timescale 1ns/1ps
module sim_cfgr_top;
    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] BASE       = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_offset = '0;
    logic        sw_rd_en = 1'b0;
    logic [11:0] sw_rd_addr = '0;
    logic        rsp_valid, rsp_remote, setup_wr;
    logic [1:0]  rsp_kind;
    logic [31:0] rsp_addr, setup_word, sw_rd_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] last_word = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgr_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_bus(req_bus),
        .req_devfn(req_devfn), .req_offset(req_offset),
        .sw_rd_en(sw_rd_en), .sw_rd_addr(sw_rd_addr),
        .rsp_valid(rsp_valid), .rsp_remote(rsp_remote), .rsp_kind(rsp_kind),
        .rsp_addr(rsp_addr), .setup_word(setup_word), .setup_wr(setup_wr),
        .sw_rd_data(sw_rd_data)
    );

    function automatic logic [31:0] exp_word(input logic [7:0] b, input logic [7:0] df);
        return {7'd0, (b > 8'd1), b, 3'd0, df[7:3], 5'd0, df[2:0]};
    endfunction

    function automatic logic [31:0] exp_addr(input logic [7:0] b, input logic [11:0] o);
        return (b == 8'd0) ? BASE + {20'd0, o} : BASE + 32'h1000 + {20'd0, o};
    endfunction

    function automatic logic [1:0] exp_kind(input logic [7:0] b);
        return (b == 8'd0) ? 2'd0 : (b == 8'd1) ? 2'd1 : 2'd2;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic [7:0] b, input logic [7:0] df, input logic [11:0] o);
        @(negedge clk);
        req_valid = 1'b1; req_bus = b; req_devfn = df; req_offset = o;
        @(posedge clk); #1;
        check("R2 valid", {31'd0, rsp_valid}, 32'd1);
        check("R7/R3 remote", {31'd0, rsp_remote}, {31'd0, b != 8'd0});
        check("R5/R6 kind", {30'd0, rsp_kind}, {30'd0, exp_kind(b)});
        check("R3/R7 addr", rsp_addr, exp_addr(b, o));
        check("R8 strobe", {31'd0, setup_wr}, {31'd0, b != 8'd0});
        if (b != 8'd0) begin
            check("R4/R5/R6 word", setup_word, exp_word(b, df));
            last_word = exp_word(b, df);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        sw_rd_en = 1'b1; sw_rd_addr = a;
        @(posedge clk); #1;
        check(req, sw_rd_data, exp);
        @(negedge clk);
        sw_rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 strobe", {31'd0, setup_wr}, 32'd0);
        @(negedge clk); rst = 1'b0;
        do_read(12'h008, 32'd0, "R1 readback");

        // R2: idle cycles produce no response
        @(posedge clk); #1;
        check("R2 idle", {31'd0, rsp_valid}, 32'd0);

        do_req(8'd0, 8'h2B, 12'h010);      // R3 local
        do_req(8'd1, 8'hFF, 12'hFFF);      // R6 bus 1, all-ones devfn, max offset
        @(posedge clk); #1;
        check("R8 single pulse", {31'd0, setup_wr}, 32'd0);
        check("R2 single valid", {31'd0, rsp_valid}, 32'd0);
        do_read(12'h008, last_word, "R9 readback");
        do_read(12'h00C, 32'd0, "R9 other addr");
        do_req(8'd2, 8'h08, 12'h000);      // R5 lowest Type 1 bus
        do_req(8'd255, 8'h07, 12'h004);    // R5 top bus
        do_req(8'd0, 8'h00, 12'h000);      // R11 local in between
        do_read(12'h008, last_word, "R11 retained");

        // R10: read in the same cycle as the strobe
        @(negedge clk);
        req_valid = 1'b1; req_bus = 8'd7; req_devfn = 8'h9A; req_offset = 12'h020;
        @(posedge clk); #1;
        @(negedge clk);
        req_valid = 1'b0; sw_rd_en = 1'b1; sw_rd_addr = 12'h008;
        @(posedge clk); #1;
        check("R10 forward", sw_rd_data, exp_word(8'd7, 8'h9A));
        last_word = exp_word(8'd7, 8'h9A);
        @(negedge clk); sw_rd_en = 1'b0;
        do_read(12'h008, last_word, "R10 settled");

        for (int i = 0; i < 200; i++) begin
            logic [7:0] b;
            int sel;
            sel = $urandom_range(0, 3);
            b = (sel == 0) ? 8'd0 : (sel == 1) ? 8'd1 : 8'($urandom_range(2, 255));
            do_req(b, 8'($urandom), 12'($urandom));
            if (i % 16 == 0)
                do_read(12'h008, last_word, "R9 random readback");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule